// File: doc/BRIEF.md
# Power-on strap capture and pin turnaround

This block manages a set of package pins that serve two purposes. During power-up their drivers stay three-stated so that external pull resistors can set their levels. The block reads those levels as configuration straps. After a fixed power-on delay, counted in reference-clock cycles, it latches the levels, raises a done flag, and turns the pins around so that they drive clock signals.

Five pins together form a frequency-select code. A sixth pin selects whether that same pin later drives a 24 MHz or a 48 MHz clock. Downstream logic reads the latched code and the 24/48 choice, and treats them as valid only while the done flag is high.

Each pin's output enable is applied only on a reference edge at which its clock source is sampled low. A pin therefore never emits a shortened first high phase.

Top module: `strap_turnaround`

## Requirements
- R1: While `rst_n` is low and right after it is released, `straps_done`, `freq_code`, `sel_24`, every output enable and every pin output are 0.
- R2: `straps_done` rises on the `DELAY_CYCLES`-th rising edge of `clk_ref` with `rst_n` high, and not earlier.
- R3: At the edge where `straps_done` rises, `freq_code[i]` takes the value of `fs_pin_in[i]` at that edge, and `sel_24` takes `sel_pin_in`. A pin level present only before that edge has no effect.
- R4: Once `straps_done` is high, `freq_code`, `sel_24` and `straps_done` keep their values until the next reset, whatever the pin inputs do.
- R5: No output enable is high while `straps_done` is low.
- R6: With `straps_done` high, `fs_pin_oe[i]` rises on the first clock edge at which `fs_clk_src[i]` is sampled low. While the source stays high the enable stays low. Once high, it stays high until reset.
- R7: `fs_pin_out[i]` follows `fs_clk_src[i]` while `fs_pin_oe[i]` is high, and is 0 while it is low.
- R8: The select pin drives `clk24_src` when `sel_24` is 1 and `clk48_src` when `sel_24` is 0. Its enable `sel_pin_oe` follows the R6 rule applied to the selected source.
- R9: A reset asserted at any time returns the block to the R1 state, and the delay count of R2 restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that times the power-on delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_pin_in | input | NUM_FS | Levels read back from the frequency-select pins |
| sel_pin_in | input | 1 | Level read back from the 24/48 select pin |
| fs_clk_src | input | NUM_FS | Clock sources to drive out on the frequency-select pins |
| clk24_src | input | 1 | 24 MHz source for the select pin |
| clk48_src | input | 1 | 48 MHz source for the select pin |
| fs_pin_out | output | NUM_FS | Output values for the frequency-select pins |
| fs_pin_oe | output | NUM_FS | Output enables for the frequency-select pins |
| sel_pin_out | output | 1 | Output value for the select pin |
| sel_pin_oe | output | 1 | Output enable for the select pin |
| freq_code | output | NUM_FS | Latched frequency-select code |
| sel_24 | output | 1 | Latched select: 1 means 24 MHz, 0 means 48 MHz |
| straps_done | output | 1 | High once the straps are latched |

## Verification
An off-by-one in the delay counter shows at `straps_done` exactly one cycle early or late. A sampling slip latches a decoy pin level that the bench applies one cycle before the capture edge, so `freq_code` is visibly wrong. A missing phase qualification raises an enable while its source is still high, on the first edge after capture. A leaky hold shows in `freq_code` on the cycle after the pins change. A missing restart on reset shows as an early done in the second power-up.

// File: rtl/strap_turnaround.sv
module strap_turnaround #(
  parameter int DELAY_CYCLES = 28636,
  parameter int NUM_FS       = 5
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [NUM_FS-1:0] fs_pin_in,
  input  logic              sel_pin_in,
  input  logic [NUM_FS-1:0] fs_clk_src,
  input  logic              clk24_src,
  input  logic              clk48_src,
  output logic [NUM_FS-1:0] fs_pin_out,
  output logic [NUM_FS-1:0] fs_pin_oe,
  output logic              sel_pin_out,
  output logic              sel_pin_oe,
  output logic [NUM_FS-1:0] freq_code,
  output logic              sel_24,
  output logic              straps_done
);

  localparam int CW = $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = (cnt == LAST);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      straps_done <= 1'b0;
      freq_code   <= '0;
      sel_24      <= 1'b0;
    end else if (!straps_done) begin
      cnt <= cnt + 1'b1;
      if (hit) begin
        straps_done <= 1'b1;
        freq_code   <= fs_pin_in;
        sel_24      <= sel_pin_in;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_FS; g++) begin : g_fs
      always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)
          fs_pin_oe[g] <= 1'b0;
        else if (straps_done && !fs_clk_src[g])
          fs_pin_oe[g] <= 1'b1;
      end
      assign fs_pin_out[g] = fs_pin_oe[g] & fs_clk_src[g];
    end
  endgenerate

  logic sel_src;
  assign sel_src = sel_24 ? clk24_src : clk48_src;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)
      sel_pin_oe <= 1'b0;
    else if (straps_done && !sel_src)
      sel_pin_oe <= 1'b1;
  end

  assign sel_pin_out = sel_pin_oe & sel_src;

  a_r2_done_at_limit: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(straps_done) |-> $past(cnt) == LAST);

  a_r4_straps_held: assert property (@(posedge clk_ref) disable iff (!rst_n)
    straps_done |=> straps_done && $stable(freq_code) && $stable(sel_24));

  a_r5_no_drive_early: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !straps_done |-> (fs_pin_oe == '0) && !sel_pin_oe);

  a_r6_oe_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
    |fs_pin_oe |=> ((fs_pin_oe & $past(fs_pin_oe)) == $past(fs_pin_oe)));

  a_r6_oe_on_low: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ((fs_pin_oe & ~$past(fs_pin_oe) & $past(fs_clk_src)) == '0));

  a_r8_sel_oe_on_low: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(sel_pin_oe) |-> !$past(sel_24 ? clk24_src : clk48_src));

endmodule

// File: tb/sim_strap_turnaround.sv
module sim_strap_turnaround;
  localparam int D = 16;
  localparam int N = 5;

  logic clk_ref = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] fs_pin_in = '0;
  logic sel_pin_in = 1'b0;
  logic [N-1:0] fs_clk_src = '1;
  logic clk24_src = 1'b1, clk48_src = 1'b1;
  logic [N-1:0] fs_pin_out, fs_pin_oe, freq_code;
  logic sel_pin_out, sel_pin_oe, sel_24, straps_done;

  int nchk = 0, nfail = 0;

  always #5 clk_ref = ~clk_ref;

  strap_turnaround #(.DELAY_CYCLES(D), .NUM_FS(N)) u0 (
    .clk_ref(clk_ref), .rst_n(rst_n), .fs_pin_in(fs_pin_in), .sel_pin_in(sel_pin_in),
    .fs_clk_src(fs_clk_src), .clk24_src(clk24_src), .clk48_src(clk48_src),
    .fs_pin_out(fs_pin_out), .fs_pin_oe(fs_pin_oe), .sel_pin_out(sel_pin_out),
    .sel_pin_oe(sel_pin_oe), .freq_code(freq_code), .sel_24(sel_24),
    .straps_done(straps_done));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    check({tag, " done"}, 32'(straps_done), 0);
    check({tag, " code"}, 32'({sel_24, freq_code}), 0);
    check({tag, " oe"}, 32'({sel_pin_oe, fs_pin_oe}), 0);
    check({tag, " out"}, 32'({sel_pin_out, fs_pin_out}), 0);
  endtask

  // {sel strap, fs straps}
  localparam logic [5:0] VEC [6] = '{6'h00, 6'h3F, 6'h15, 6'h2A, 6'h13, 6'h2C};

  task automatic powerup(input logic [5:0] v);
    @(negedge clk_ref); rst_n = 1'b0;
    fs_clk_src = '1; clk24_src = 1'b1; clk48_src = 1'b1;
    fs_pin_in = ~v[4:0]; sel_pin_in = ~v[5];
    @(negedge clk_ref);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (D - 1) @(posedge clk_ref);
    @(negedge clk_ref);
    check("R2 early", 32'(straps_done), 0);
    check("R5 before done", 32'({sel_pin_oe, fs_pin_oe}), 0);
    fs_pin_in = v[4:0]; sel_pin_in = v[5];
    @(negedge clk_ref);
    check("R2 rise", 32'(straps_done), 1);
    check("R3 code", 32'({sel_24, freq_code}), 32'(v));
  endtask

  initial begin
    for (int k = 0; k < 6; k++) begin
      powerup(VEC[k]);
      fs_pin_in = ~VEC[k][4:0]; sel_pin_in = ~VEC[k][5];
      repeat (3) @(negedge clk_ref);
      check("R4 hold", 32'({straps_done, sel_24, freq_code}), 32'({1'b1, VEC[k]}));
    end

    // R6/R7: sources high keep enables low
    powerup(6'h25);
    repeat (2) @(negedge clk_ref);
    check("R6 src high", 32'(fs_pin_oe), 0);
    check("R7 out off", 32'(fs_pin_out), 0);
    fs_clk_src[2] = 1'b0;
    @(negedge clk_ref);
    check("R6 enable on low", 32'(fs_pin_oe), 32'h04);
    check("R7 low phase", 32'(fs_pin_out), 0);
    fs_clk_src[2] = 1'b1;
    #1 check("R7 follows", 32'(fs_pin_out), 32'h04);
    @(negedge clk_ref);
    check("R6 sticky", 32'(fs_pin_oe), 32'h04);
    fs_clk_src = '0;
    @(negedge clk_ref);
    check("R6 all on", 32'(fs_pin_oe), 32'h1F);
    fs_clk_src = 5'h0A;
    #1 check("R7 pattern", 32'(fs_pin_out), 32'h0A);

    // R8: sel_24=1 selects 24 MHz source
    check("R8 sel latched", 32'(sel_24), 1);
    clk24_src = 1'b1; clk48_src = 1'b0;
    @(negedge clk_ref);
    check("R8 48 ignored", 32'(sel_pin_oe), 0);
    clk24_src = 1'b0;
    @(negedge clk_ref);
    check("R8 oe", 32'(sel_pin_oe), 1);
    clk24_src = 1'b1; clk48_src = 1'b0;
    #1 check("R8 drives 24", 32'(sel_pin_out), 1);

    // R8: sel_24=0 selects 48 MHz source
    powerup(6'h01);
    clk24_src = 1'b0; clk48_src = 1'b1;
    @(negedge clk_ref);
    check("R8 24 ignored", 32'(sel_pin_oe), 0);
    clk48_src = 1'b0;
    @(negedge clk_ref);
    check("R8 oe 48", 32'(sel_pin_oe), 1);
    clk48_src = 1'b1;
    #1 check("R8 drives 48", 32'(sel_pin_out), 1);

    // R9: reset mid-count restarts the delay
    @(negedge clk_ref); rst_n = 1'b0;
    @(negedge clk_ref);
    check_idle("R9 reset");
    fs_clk_src = '1; clk24_src = 1'b1; clk48_src = 1'b1;
    rst_n = 1'b1;
    repeat (8) @(negedge clk_ref);
    rst_n = 1'b0;
    @(negedge clk_ref);
    check_idle("R9 mid reset");
    fs_pin_in = 5'h11; sel_pin_in = 1'b1;
    rst_n = 1'b1;
    repeat (D - 1) @(negedge clk_ref);
    check("R9 restart early", 32'(straps_done), 0);
    @(negedge clk_ref);
    check("R9 restart done", 32'({straps_done, sel_24, freq_code}), 32'h71);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule